// File: doc/BRIEF.md
# Double-Buffered Serial DAC Load Interface

This block is the digital front end of a converter that is loaded over a serial line. It has three wires: an active-low select, a serial clock and a data input. A host shifts in one 16-bit word per select window, most significant bit first. When select is released after exactly sixteen clock pulses, the word moves into a holding latch and its four-bit control field is decoded.

The data path has two stages, an input latch and a converter latch. Depending on the control field, one word does one of three things:

- it stages a new code in the input latch only;
- it promotes the staged code to the converter latch;
- it writes the new code to both latches at once.

The code on the output follows the converter latch only. All serial pins are brought into the system clock domain, and every write of the converter latch raises a single-cycle strobe.

The resolution is set by a parameter to 12, 10 or 8 bits. A reduced resolution takes the upper bits of the 12-bit data field and ignores the rest. A synchronous reset clears every latch.

Top module: `sdac_front`

## Requirements
- R1: A word carries the control field in its upper four bits (bits 15..12) and a 12-bit data field in bits 11..0. It is shifted in most significant bit first.
- R2: A data bit is taken on each rising edge of the serial clock that occurs while select is low.
- R3: The control field acts only when select rises after exactly 16 serial clock rising edges. A window with any other count changes neither latch and raises no strobe.
- R4: Serial clock edges while select is high are ignored and do not count toward the next word.
- R5: Control value 4'b0001 writes the data into the input latch only. The output code does not change.
- R6: Control value 4'b0010 copies the input latch into the converter latch.
- R7: Control value 4'b0011 writes the data into both latches in the same operation.
- R8: Any other control value leaves both latches unchanged.
- R9: With resolution RES, the output code is data bits 11 down to 12-RES. The lower data bits have no effect.
- R10: `dac_upd` is a one-cycle pulse on each write of the converter latch. The output code never changes without it.
- R11: Reset clears the holding latch, the input latch and the converter latch, so the output code is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | RES | Converter latch contents |
| dac_upd | output | 1 | One-cycle strobe on converter latch write |

## Verification
The following are checked on every cycle:

- the output code moves only together with the strobe;
- the strobe never lasts two cycles;
- a strobe always traces back to a completed word;
- a word completes only at a count of sixteen;
- the bit count stays cleared while select is high;
- reset leaves a zero code.

Only the bench scenarios can show the rest: the effect of each of the sixteen control values on both latches, the exhaustive 8-bit code sweep with junk in the ignored low bits, the discarding of short and long windows, and the blocking of clock pulses sent while select is high.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int WORD_W  = 16;
    localparam int CTRL_W  = 4;
    localparam int FIELD_W = WORD_W - CTRL_W;
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    localparam logic [CTRL_W-1:0] CTRL_STAGE   = 4'b0001;
    localparam logic [CTRL_W-1:0] CTRL_PROMOTE = 4'b0010;
    localparam logic [CTRL_W-1:0] CTRL_BOTH    = 4'b0011;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_STAGE,
        ACT_PROMOTE,
        ACT_BOTH
    } act_e;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [FIELD_W-1:0] data;
    } frame_t;

    function automatic act_e decode_ctrl(input logic [CTRL_W-1:0] c);
        case (c)
            CTRL_STAGE:   return ACT_STAGE;
            CTRL_PROMOTE: return ACT_PROMOTE;
            CTRL_BOTH:    return ACT_BOTH;
            default:      return ACT_NONE;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
        return (c >= CNT_OVER) ? CNT_OVER : c + 1'b1;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q_out,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d_in[b]};
        end
        assign q_out[b] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= q_out;
    end

    assign rise = q_out & ~prev_q;
    assign fall = ~q_out & prev_q;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_hi,
    input  logic             cs_rise,
    input  logic             sck_rise,
    input  logic             sdi_s,
    output frame_t           frame,
    output logic             frame_vld,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            frame     <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (cs_hi) begin
                if (cs_rise && bit_cnt == CNT_FULL) begin
                    frame     <= frame_t'(shreg);
                    frame_vld <= 1'b1;
                end
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[WORD_W-2:0], sdi_s};
                bit_cnt <= count_step(bit_cnt);
            end
        end
    end
endmodule

// File: rtl/sdac_latches.sv
module sdac_latches
    import sdac_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  frame_t         frame,
    input  logic           frame_vld,
    output logic [RES-1:0] dac_q,
    output logic           upd
);
    act_e           act_q;
    logic [RES-1:0] data_q;
    logic [RES-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= ACT_NONE;
            data_q <= '0;
            in_q   <= '0;
            dac_q  <= '0;
            upd    <= 1'b0;
        end else begin
            upd   <= 1'b0;
            act_q <= frame_vld ? decode_ctrl(frame.ctrl) : ACT_NONE;
            if (frame_vld) data_q <= frame.data[FIELD_W-1 -: RES];
            case (act_q)
                ACT_STAGE: in_q <= data_q;
                ACT_PROMOTE: begin
                    dac_q <= in_q;
                    upd   <= 1'b1;
                end
                ACT_BOTH: begin
                    in_q  <= data_q;
                    dac_q <= data_q;
                    upd   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int RES    = 12,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           sdi,
    output logic [RES-1:0] dac_code,
    output logic           dac_upd
);
    logic [2:0]       pins_s, pins_r, pins_f;
    logic             cs_hi, cs_rise, sck_rise, sdi_s;
    frame_t           frame;
    logic             frame_vld;
    logic [CNT_W-1:0] bit_cnt;

    sdac_sync #(.N(3), .STAGES(STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst), .d_in({sdi, sclk, cs_n}),
        .q_out(pins_s), .rise(pins_r), .fall(pins_f)
    );

    assign cs_hi    = pins_s[0];
    assign cs_rise  = pins_r[0];
    assign sck_rise = pins_r[1];
    assign sdi_s    = pins_s[2];

    sdac_shifter u_shift (
        .clk(clk), .rst(rst), .cs_hi(cs_hi), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sdi_s(sdi_s), .frame(frame),
        .frame_vld(frame_vld), .bit_cnt(bit_cnt)
    );

    sdac_latches #(.RES(RES)) u_lat (
        .clk(clk), .rst(rst), .frame(frame), .frame_vld(frame_vld),
        .dac_q(dac_code), .upd(dac_upd)
    );
endmodule

// File: rtl/sdac_chk.sv
module sdac_chk
    import sdac_pkg::*;
#(
    parameter int RES = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_hi,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             frame_vld,
    input logic [RES-1:0]   dac_code,
    input logic             dac_upd
);
    AST_CODE_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        (dac_code != $past(dac_code)) |-> dac_upd); // R10
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dac_upd |=> !dac_upd); // R10
    AST_STROBE_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        dac_upd |-> $past(frame_vld, 2)); // R3
    AST_WORD_AT_SIXTEEN: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> $past(bit_cnt) == CNT_FULL); // R3
    AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cs_hi && $past(cs_hi)) |-> bit_cnt == '0); // R4
    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == '0 && !dac_upd)); // R11
endmodule

bind sdac_front sdac_chk #(.RES(RES)) u_chk (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .bit_cnt(bit_cnt),
    .frame_vld(frame_vld), .dac_code(dac_code), .dac_upd(dac_upd)
);

// File: tb/tb_sdac_front.sv
module tb_sdac_front;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [11:0] code12;
    logic [7:0]  code8;
    logic        upd12, upd8;
    int vectors = 0, errors = 0;
    int p12 = 0, p8 = 0;
    logic [11:0] m_in = '0, m_dac = '0;

    always #5 clk = ~clk;

    sdac_front #(.RES(12)) dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .dac_code(code12), .dac_upd(upd12));
    sdac_front #(.RES(8)) dut8 (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .dac_code(code8), .dac_upd(upd8));

    always @(negedge clk) begin
        if (upd12) p12++;
        if (upd8)  p8++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    // sends nb clock pulses; junk pulses first while select is high
    task automatic send(input logic [15:0] w, input int nb, input int junk, input string req);
        int s12 = p12, s8 = p8, ep = 0;
        for (int j = 0; j < junk; j++) begin
            sdi = ~sdi; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
        tick(4); cs_n = 1'b0; tick(4);
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b1;
            tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
        tick(4); cs_n = 1'b1; tick(14);
        if (nb == 16) begin
            case (w[15:12])
                4'b0001: m_in = w[11:0];
                4'b0010: begin m_dac = m_in; ep = 1; end
                4'b0011: begin m_in = w[11:0]; m_dac = w[11:0]; ep = 1; end
                default: ;
            endcase
        end
        chk({req, " code12"}, int'(code12), int'(m_dac));
        chk({req, " code8"},  int'(code8),  int'(m_dac[11:4]));
        chk({req, " strobe12"}, p12 - s12, ep);
        chk({req, " strobe8"},  p8 - s8,   ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tick(6); rst = 1'b0; tick(2);
        chk("R11 reset code12", int'(code12), 0);
        chk("R11 reset code8", int'(code8), 0);
        chk("R11 reset strobe", int'(upd12), 0);

        send(16'h3A5C, 16, 0, "R1 R2 R7 both");
        send(16'h1123, 16, 0, "R5 stage only");
        send(16'h2000, 16, 0, "R6 promote");
        send(16'h2FFF, 16, 0, "R6 promote repeat");

        // every control value, staged latch revealed afterwards by a promote
        for (int c = 0; c < 16; c++) begin
            send(16'h3111 + 16'(c), 16, 0, "R8 base");
            send({4'(c), 12'hE5B ^ 12'(c * 37)}, 16, 0, "R5 R6 R7 R8 ctrl sweep");
            send(16'h2000, 16, 0, "R8 reveal input latch");
        end

        // windows of the wrong length are dropped
        send(16'h3ABC, 15, 0, "R3 short window");
        send(16'h3ABC, 17, 0, "R3 long window");
        send(16'h3ABC, 0, 0, "R3 empty window");
        send(16'h2000, 16, 0, "R3 input latch untouched");

        // clocks while select is high must not count
        send(16'h3D2E, 16, 5, "R4 blocked clocks");
        send(16'h1777, 16, 3, "R4 blocked clocks stage");
        send(16'h2000, 16, 0, "R4 promote after blocked");

        // exhaustive 8-bit codes with junk in the ignored low bits
        for (int k = 0; k < 256; k++)
            send({4'b0011, 8'(k), 4'((k * 7) ^ 4'hA)}, 16, 0, "R9 resolution sweep");

        // mid-run reset clears both latches
        send(16'h3C3C, 16, 0, "R11 preload");
        send(16'h1555, 16, 0, "R11 preload stage");
        tick(2); rst = 1'b1; tick(3); rst = 1'b0; tick(2);
        m_in = '0; m_dac = '0;
        chk("R11 reset after load", int'(code12), 0);
        send(16'h2000, 16, 0, "R11 input latch cleared");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule